// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Unit

This block holds the pending-interrupt state of a multi-channel DMA controller. Each channel has a completion flag, and one further flag records an error on any channel. The channel engines report each finished descriptor with a one-cycle pulse. The pulse comes with two bits from that descriptor: whether it chains to another descriptor, and whether it asks for a notification. The error source reports with a pulse of its own.

Software works the block through three write ports: a clear mask, a force mask and an enable mask. It reads the flags and the enables back on two output vectors. One registered interrupt line goes to the processor whenever a pending flag has its enable set. For a chained completion the block also issues a same-cycle request to load the next descriptor.

Top module: `dma_irq_flags`

## Requirements
- R1: The flag vector is NUM_CH+1 bits wide. Bit i (0 to NUM_CH-1) is the completion flag of channel i, and bit NUM_CH is the shared error flag. `flags` and `enables` show the registered flag and enable state.
- R2: A completion pulse with notify=1 sets that channel's flag at the next clock edge.
- R3: A completion pulse with link=1 and notify=0 leaves that channel's flag unchanged.
- R4: A completion pulse with link=0 sets that channel's flag at the next clock edge, whatever the value of notify.
- R5: `link_load[i]` is high in the same cycle as a completion pulse on channel i that has link=1, whatever the value of notify, and is low otherwise.
- R6: An `err_pulse` sets flag bit NUM_CH at the next clock edge.
- R7: A clear write with a 1 in a bit clears that flag. A 0 in a bit leaves that flag unchanged.
- R8: When a clear write and a set event (completion, error or force) hit the same flag in the same cycle, the flag ends up set.
- R9: A force write with a 1 in a bit sets that flag at the next clock edge. A 0 in a bit has no effect.
- R10: An enable write replaces the whole enable vector. `irq` rises one clock edge after a flag and its matching enable are both set.
- R11: `irq` stays low while no flag has its enable set. It falls one clock edge after the last pending enabled flag is cleared.
- R12: Reset clears all flags, all enables and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmpl_valid | input | NUM_CH | Per-channel descriptor completion pulse |
| cmpl_link | input | NUM_CH | Link bit of the completing descriptor |
| cmpl_notify | input | NUM_CH | Notification-enable bit of the completing descriptor |
| err_pulse | input | 1 | Error event from any channel |
| clr_we | input | 1 | Clear-mask write strobe |
| clr_data | input | NUM_CH+1 | Clear mask, 1 clears the flag |
| set_we | input | 1 | Force-mask write strobe |
| set_data | input | NUM_CH+1 | Force mask, 1 sets the flag |
| en_we | input | 1 | Enable write strobe |
| en_data | input | NUM_CH+1 | New enable vector |
| flags | output | NUM_CH+1 | Registered flag vector |
| enables | output | NUM_CH+1 | Registered enable vector |
| link_load | output | NUM_CH | Same-cycle next-descriptor load request |
| irq | output | 1 | Registered combined interrupt request |

## Verification
A software clear of a flag can land in the same cycle as a hardware event that sets the same flag. The bench makes this happen by raising a completion pulse, an error pulse or a force write on the same negative edge as a clear write. It then reads the flag after the next rising edge and expects it to be set. A second case checks that the clear still acts on the other bits in that same cycle. The timing of the interrupt line is judged against flag changes, one edge later in each direction.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    // A finished descriptor raises its channel flag when it asked for
    // notification, or when it ends the chain.
    function automatic logic done_event(input logic valid,
                                        input logic link,
                                        input logic notify);
        return valid && (notify || !link);
    endfunction

endpackage

// File: rtl/dma_irq_event.sv
module dma_irq_event #(
    parameter int NUM_CH = 4,
    localparam int FW = NUM_CH + 1
) (
    input  logic [NUM_CH-1:0] cmpl_valid,
    input  logic [NUM_CH-1:0] cmpl_link,
    input  logic [NUM_CH-1:0] cmpl_notify,
    input  logic              err_pulse,
    output logic [FW-1:0]     set_evt,
    output logic [NUM_CH-1:0] link_load
);
    import dma_irq_pkg::*;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_comb begin
            set_evt[ch]   = done_event(cmpl_valid[ch], cmpl_link[ch], cmpl_notify[ch]);
            link_load[ch] = cmpl_valid[ch] && cmpl_link[ch];
        end
    end

    always_comb set_evt[NUM_CH] = err_pulse;

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs #(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] set_evt,
    input  logic          clr_we,
    input  logic [FW-1:0] clr_data,
    input  logic          set_we,
    input  logic [FW-1:0] set_data,
    input  logic          en_we,
    input  logic [FW-1:0] en_data,
    output logic [FW-1:0] flags_q,
    output logic [FW-1:0] en_q
);
    typedef struct packed {
        logic [FW-1:0] flags;
        logic [FW-1:0] en;
    } regs_t;

    regs_t r_d, r_q;
    logic [FW-1:0] clr_mask_d, force_mask_d;

    always_comb begin
        clr_mask_d   = clr_we ? clr_data : '0;
        force_mask_d = set_we ? set_data : '0;
        r_d          = r_q;
        // Set sources are ORed in after the clear, so a set always wins.
        r_d.flags    = (r_q.flags & ~clr_mask_d) | set_evt | force_mask_d;
        if (en_we) r_d.en = en_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags_q = r_q.flags;
    assign en_q    = r_q.en;

    for (genvar b = 0; b < FW; b++) begin : g_chk
        assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (set_evt[b] || (set_we && set_data[b])) |=> flags_q[b]);
        assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[b] && !set_evt[b] && !(set_we && set_data[b])) |=> !flags_q[b]);
        assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!(clr_we && clr_data[b]) && flags_q[b]) |=> flags_q[b]);
    end

endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine #(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flags_q,
    input  logic [FW-1:0] en_q,
    output logic          irq_q
);
    logic irq_d;
    logic pending;

    always_comb begin
        pending = |(flags_q & en_q);
        irq_d   = pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_q);
    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_q);

endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
    parameter int NUM_CH = 4,
    localparam int FW = NUM_CH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cmpl_valid,
    input  logic [NUM_CH-1:0] cmpl_link,
    input  logic [NUM_CH-1:0] cmpl_notify,
    input  logic              err_pulse,
    input  logic              clr_we,
    input  logic [FW-1:0]     clr_data,
    input  logic              set_we,
    input  logic [FW-1:0]     set_data,
    input  logic              en_we,
    input  logic [FW-1:0]     en_data,
    output logic [FW-1:0]     flags,
    output logic [FW-1:0]     enables,
    output logic [NUM_CH-1:0] link_load,
    output logic              irq
);
    logic [FW-1:0] set_evt;

    dma_irq_event #(.NUM_CH(NUM_CH)) u_event (
        .cmpl_valid (cmpl_valid),
        .cmpl_link  (cmpl_link),
        .cmpl_notify(cmpl_notify),
        .err_pulse  (err_pulse),
        .set_evt    (set_evt),
        .link_load  (link_load)
    );

    dma_irq_regs #(.FW(FW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_evt),
        .clr_we  (clr_we),
        .clr_data(clr_data),
        .set_we  (set_we),
        .set_data(set_data),
        .en_we   (en_we),
        .en_data (en_data),
        .flags_q (flags),
        .en_q    (enables)
    );

    dma_irq_combine #(.FW(FW)) u_comb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags_q(flags),
        .en_q   (enables),
        .irq_q  (irq)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        assert_notify_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl_valid[ch] && cmpl_notify[ch]) |=> flags[ch]);
        assert_chain_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl_valid[ch] && cmpl_link[ch] && !cmpl_notify[ch] && !flags[ch]
             && !(set_we && set_data[ch])) |=> !flags[ch]);
        assert_last_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmpl_valid[ch] && !cmpl_link[ch]) |=> flags[ch]);
        assert_no_stray_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !cmpl_valid[ch] |-> !link_load[ch]);
    end

    assert_err_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> flags[NUM_CH]);

endmodule

// File: tb/tb_dma_irq_flags.sv
module tb_dma_irq_flags;
    localparam int NCH = 4;
    localparam int FW  = NCH + 1;

    logic clk = 0, rst_n = 0;
    logic [NCH-1:0] cmpl_valid = '0, cmpl_link = '0, cmpl_notify = '0;
    logic err_pulse = 0, clr_we = 0, set_we = 0, en_we = 0;
    logic [FW-1:0] clr_data = '0, set_data = '0, en_data = '0;
    logic [FW-1:0] flags, enables;
    logic [NCH-1:0] link_load;
    logic irq;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    dma_irq_flags #(.NUM_CH(NCH)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmpl_valid = '0; cmpl_link = '0; cmpl_notify = '0; err_pulse = 0;
        clr_we = 0; set_we = 0; en_we = 0;
    endtask

    // Inputs set at a negedge are registered at the following posedge;
    // flags are read at the next negedge, irq one negedge later.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic clear_all();
        @(negedge clk); idle(); clr_we = 1; clr_data = '1;
        tick(); tick();
    endtask

    task automatic t_reset();
        check("R12 flags", flags, 0);
        check("R12 enables", enables, 0);
        check("R12 irq", irq, 0);
    endtask

    task automatic t_notify();
        @(negedge clk); cmpl_valid = 4'b0010; cmpl_link = 4'b0010; cmpl_notify = 4'b0010;
        #1 check("R5 link_load notify", link_load, 4'b0010);
        tick();
        check("R2 notify sets", flags, 5'b00010);
        clear_all();
    endtask

    task automatic t_link_silent();
        @(negedge clk); cmpl_valid = 4'b0100; cmpl_link = 4'b0100; cmpl_notify = 4'b0000;
        #1 check("R5 link_load silent", link_load, 4'b0100);
        tick();
        check("R3 chained quiet", flags, 0);
        #1 check("R5 no load idle", link_load, 0);
    endtask

    task automatic t_last();
        @(negedge clk); cmpl_valid = 4'b1001; cmpl_link = 4'b0000; cmpl_notify = 4'b0001;
        #1 check("R5 no load on last", link_load, 0);
        tick();
        check("R4 last always sets", flags, 5'b01001);
        clear_all();
    endtask

    task automatic t_error();
        @(negedge clk); err_pulse = 1;
        tick();
        check("R6 error bit", flags, 5'b10000);
        check("R1 error position", flags[NCH], 1);
        clear_all();
    endtask

    task automatic t_clear();
        @(negedge clk); set_we = 1; set_data = 5'b10111;
        tick();
        check("R9 force", flags, 5'b10111);
        @(negedge clk); set_we = 1; set_data = 5'b00000;
        tick();
        check("R9 zero force no effect", flags, 5'b10111);
        @(negedge clk); clr_we = 1; clr_data = 5'b00101;
        tick();
        check("R7 partial clear", flags, 5'b10010);
        @(negedge clk); clr_we = 1; clr_data = 5'b00000;
        tick();
        check("R7 zero clear keeps", flags, 5'b10010);
        clear_all();
    endtask

    task automatic t_collide();
        @(negedge clk); set_we = 1; set_data = 5'b01100;
        tick();
        @(negedge clk);
        clr_we = 1; clr_data = 5'b11111;
        cmpl_valid = 4'b0001; cmpl_link = 4'b0000;
        err_pulse = 1;
        set_we = 1; set_data = 5'b01000;
        tick();
        check("R8 set wins over clear", flags, 5'b11001);
        clear_all();
        check("R7 clear all", flags, 0);
    endtask

    task automatic t_irq();
        @(negedge clk); en_we = 1; en_data = 5'b00100;
        tick();
        check("R10 enables", enables, 5'b00100);
        @(negedge clk); set_we = 1; set_data = 5'b00010;
        tick(); tick();
        check("R11 masked flag no irq", irq, 0);
        @(negedge clk); cmpl_valid = 4'b0100; cmpl_notify = 4'b0100;
        tick();
        check("R10 irq not yet", irq, 0);
        tick();
        check("R10 irq raised", irq, 1);
        @(negedge clk); clr_we = 1; clr_data = 5'b00100;
        tick();
        check("R11 irq lags clear", irq, 1);
        tick();
        check("R11 irq dropped", irq, 0);
        @(negedge clk); en_we = 1; en_data = 5'b00010;
        tick();
        check("R10 enable replaced", enables, 5'b00010);
        tick();
        check("R10 irq on new enable", irq, 1);
        @(negedge clk); rst_n = 0;
        #1;
        check("R12 reset flags", flags, 0);
        check("R12 reset enables", enables, 0);
        check("R12 reset irq", irq, 0);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_notify();
        t_link_silent();
        t_last();
        t_error();
        t_clear();
        t_collide();
        t_irq();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule